// File: doc/BRIEF.md
# Read/Write Batching Request Grouper

This block sits between request sources and a memory-request scheduler and sorts the request stream by direction, so that the scheduler sees long runs of reads and long runs of writes. Fewer changes of direction mean fewer bus turnarounds on the memory interface. Requests carry an address and a direction flag, and they arrive on a valid/ready upstream port. They leave on a valid/ready downstream port. Each completion reported by the scheduler arrives as a one-cycle pulse.

Reads are favoured. A read passes straight through unless a write waiting in the block targets the same address. When a read does hit such a write, the block stops forwarding new requests. It waits until every request already sent downstream has completed. It then releases the waiting writes ahead of that read, so the read sees the written data. The block keeps its own count of outstanding requests. It adds one for each downstream handshake and subtracts one for each completion. A count of zero means the scheduler is empty.

The controller has five states. `ST_READ` is read mode. `ST_HOLD` drains requests already issued before the writes are released. `ST_WRITE` is write mode. `ST_WFLUSH` empties the write queue on the way into write mode. `ST_RFLUSH` empties the read queue on the way into read mode. The transitions are:
- read→hold: a read hits a queued write.
- read→wflush: the scheduler empties while writes wait, or a write arrives while nothing is outstanding.
- hold→wflush: the scheduler empties.
- wflush→write: the write queue is empty and requests are still outstanding.
- wflush→rflush: the write queue is empty and nothing is outstanding.
- write→rflush: the scheduler empties.
- rflush→read: the read queue is empty.

Top module: `rw_batch_grouper`

## Requirements
- R1: After reset the block is in read mode with no outstanding requests. dn_valid is low, and up_ready is high for a read while dn_ready is high.
- R2: In read mode, a read whose address matches no queued write appears on the downstream port in the same cycle (dn_valid follows up_valid, dn_is_write=0, dn_addr=up_addr), and up_ready follows dn_ready.
- R3: In read mode, a write that arrives while requests are outstanding is accepted and held; it does not appear downstream.
- R4: In read mode, a write that arrives while nothing is outstanding is held, and the block enters write mode. The write appears downstream in the next cycle, and later writes are forwarded directly.
- R5: A read in read mode whose address equals that of any queued write is held, and the block enters the hold state. In the hold state every new read and write is held, and dn_valid stays low.
- R6: When the outstanding count reaches zero in the hold state, or in read mode while writes are queued, all queued writes are sent downstream in arrival order (dn_is_write=1).
- R7: In write mode, a write appears downstream in the same cycle with dn_is_write=1, and a read is accepted but held.
- R8: When the outstanding count reaches zero in write mode, all held reads are sent downstream in arrival order (dn_is_write=0), and the block returns to read mode.
- R9: During a queue flush, up_ready is low, one entry is offered per cycle, and the offered entry stays unchanged while dn_ready is low.
- R10: up_ready is low when the queue that the presented request would enter is full (DEPTH entries, 8 by default). A refused request is not stored.
- R11: The outstanding count rises by one on each downstream handshake and falls by one on each done pulse. Only the transition to zero triggers a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_is_write | input | 1 | Upstream direction, 1 = write |
| up_addr | input | AW | Upstream request address |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Scheduler accepts request |
| dn_is_write | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | AW | Downstream request address |
| done | input | 1 | One-cycle completion pulse from the scheduler |

## Verification
The hardest case to reach is a read-after-write conflict that occurs while several reads are still outstanding, followed by more traffic in the hold state. The sequence matters because the queued writes must leave before the conflicting read, which in turn leaves before later reads. The stimulus first issues reads and holds some writes. It then presents a read to a held write's address, adds a read and a write while the block holds, and only after that releases the completions one at a time. It also stalls dn_ready during the write flush. The downstream order is then compared entry by entry with the expected order.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
    typedef enum logic [2:0] {
        ST_READ   = 3'd0,
        ST_HOLD   = 3'd1,
        ST_WRITE  = 3'd2,
        ST_WFLUSH = 3'd3,
        ST_RFLUSH = 3'd4
    } rwg_state_e;
endpackage

// File: rtl/rwg_queue.sv
module rwg_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter bit MATCH = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic          empty,
    output logic          full,
    input  logic [AW-1:0] probe_addr,
    output logic          probe_hit
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0]    slot_q [DEPTH];
    logic [DEPTH-1:0] live_q;
    logic [PW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CW'(DEPTH));
    assign head_addr = slot_q[rd_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= '0;
            rd_q   <= '0;
            cnt_q  <= '0;
            live_q <= '0;
        end else begin
            if (push) begin
                slot_q[wr_q] <= push_addr;
                wr_q         <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (pop) begin
                rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (push && (PW'(i) == wr_q))     live_q[i] <= 1'b1;
                else if (pop && (PW'(i) == rd_q)) live_q[i] <= 1'b0;
            end
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    generate
        if (MATCH) begin : g_match
            logic [DEPTH-1:0] eq;
            for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
                assign eq[g] = live_q[g] && (slot_q[g] == probe_addr);
            end
            assign probe_hit = |eq;
        end else begin : g_nomatch
            assign probe_hit = 1'b0;
        end
    endgenerate

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rwg_outstanding.sv
module rwg_outstanding #(
    parameter int MAX_OUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic is_zero,
    output logic hits_zero
);
    localparam int CW = $clog2(MAX_OUT + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    assign cnt_d     = cnt_q + CW'(inc) - CW'(dec);
    assign is_zero   = (cnt_q == '0);
    assign hits_zero = !is_zero && (cnt_d == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R11
    done_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (!is_zero || inc));
    // R11
    count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec) |-> (cnt_q != CW'(MAX_OUT)));
endmodule

// File: rtl/rw_batch_grouper.sv
module rw_batch_grouper
    import rwg_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DEPTH   = 8,
    parameter int MAX_OUT = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic          up_is_write,
    input  logic [AW-1:0] up_addr,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic          dn_is_write,
    output logic [AW-1:0] dn_addr,
    input  logic          done
);
    rwg_state_e state_q, state_d;

    logic          wq_push, wq_pop, wq_empty, wq_full, raw_hit;
    logic          rq_push, rq_pop, rq_empty, rq_full, rq_hit_unused;
    logic [AW-1:0] wq_head, rq_head;
    logic          out_zero, out_hits_zero, dn_hs;

    rwg_queue #(.DEPTH(DEPTH), .AW(AW), .MATCH(1'b1)) u_wq (
        .clk(clk), .rst_n(rst_n),
        .push(wq_push), .push_addr(up_addr), .pop(wq_pop),
        .head_addr(wq_head), .empty(wq_empty), .full(wq_full),
        .probe_addr(up_addr), .probe_hit(raw_hit)
    );

    rwg_queue #(.DEPTH(DEPTH), .AW(AW), .MATCH(1'b0)) u_rq (
        .clk(clk), .rst_n(rst_n),
        .push(rq_push), .push_addr(up_addr), .pop(rq_pop),
        .head_addr(rq_head), .empty(rq_empty), .full(rq_full),
        .probe_addr(up_addr), .probe_hit(rq_hit_unused)
    );

    rwg_outstanding #(.MAX_OUT(MAX_OUT)) u_out (
        .clk(clk), .rst_n(rst_n),
        .inc(dn_hs), .dec(done),
        .is_zero(out_zero), .hits_zero(out_hits_zero)
    );

    assign dn_hs = dn_valid && dn_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READ;
        else        state_q <= state_d;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READ: begin
                if ((out_hits_zero || out_zero) && (!wq_empty || wq_push || rq_push))
                    state_d = ST_WFLUSH;
                else if (rq_push)
                    state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (out_hits_zero || out_zero) state_d = ST_WFLUSH;
            end
            ST_WRITE: begin
                if (out_hits_zero) state_d = ST_RFLUSH;
            end
            ST_WFLUSH: begin
                if (wq_empty) state_d = out_zero ? ST_RFLUSH : ST_WRITE;
            end
            ST_RFLUSH: begin
                if (rq_empty) state_d = ST_READ;
            end
            default: state_d = ST_READ;
        endcase
    end

    // port and queue control
    always_comb begin
        up_ready    = 1'b0;
        dn_valid    = 1'b0;
        dn_is_write = 1'b0;
        dn_addr     = up_addr;
        wq_push     = 1'b0;
        rq_push     = 1'b0;
        wq_pop      = 1'b0;
        rq_pop      = 1'b0;
        unique case (state_q)
            ST_READ: begin
                if (up_is_write) begin
                    up_ready = !wq_full;
                    wq_push  = up_valid && !wq_full;
                end else if (raw_hit) begin
                    up_ready = !rq_full;
                    rq_push  = up_valid && !rq_full;
                end else begin
                    dn_valid = up_valid;
                    up_ready = dn_ready;
                end
            end
            ST_HOLD: begin
                if (up_is_write) begin
                    up_ready = !wq_full;
                    wq_push  = up_valid && !wq_full;
                end else begin
                    up_ready = !rq_full;
                    rq_push  = up_valid && !rq_full;
                end
            end
            ST_WRITE: begin
                if (up_is_write) begin
                    dn_valid    = up_valid;
                    dn_is_write = 1'b1;
                    up_ready    = dn_ready;
                end else begin
                    up_ready = !rq_full;
                    rq_push  = up_valid && !rq_full;
                end
            end
            ST_WFLUSH: begin
                dn_valid    = !wq_empty;
                dn_is_write = 1'b1;
                dn_addr     = wq_head;
                wq_pop      = !wq_empty && dn_ready;
            end
            ST_RFLUSH: begin
                dn_valid = !rq_empty;
                dn_addr  = rq_head;
                rq_pop   = !rq_empty && dn_ready;
            end
            default: ;
        endcase
    end

    // R5
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !dn_valid);
    // R7
    write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && dn_valid) |-> dn_is_write);
    // R2
    read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && dn_valid) |-> !dn_is_write);
    // R9
    flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WFLUSH || state_q == ST_RFLUSH) && dn_valid && !dn_ready)
        |=> (dn_valid && $stable(dn_addr) && $stable(dn_is_write)));
    // R6
    wflush_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && out_hits_zero) |=> (state_q == ST_WFLUSH));
endmodule

// File: tb/rw_batch_grouper_tb.sv
module rw_batch_grouper_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          up_valid, up_is_write, dn_ready, done;
    logic [AW-1:0] up_addr;
    logic          up_ready, dn_valid, dn_is_write;
    logic [AW-1:0] dn_addr;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    rw_batch_grouper #(.AW(AW), .DEPTH(8), .MAX_OUT(64)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready),
        .up_is_write(up_is_write), .up_addr(up_addr),
        .dn_valid(dn_valid), .dn_ready(dn_ready),
        .dn_is_write(dn_is_write), .dn_addr(dn_addr),
        .done(done)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_up(logic v, logic w, logic [AW-1:0] a);
        up_valid    = v;
        up_is_write = w;
        up_addr     = a;
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        dn_ready = 1'b1;
        done     = 1'b0;
        set_up(1'b0, 1'b0, '0);
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        chk("R1 dn_valid", 32'(dn_valid), 32'd0);
        chk("R1 up_ready", 32'(up_ready), 32'd1);
    endtask

    task automatic t_idle_write();
        do_reset();
        set_up(1'b1, 1'b1, 32'h80);
        #1;
        chk("R4 held dn_valid", 32'(dn_valid), 32'd0);
        chk("R4 up_ready", 32'(up_ready), 32'd1);
        step();
        set_up(1'b0, 1'b0, '0);
        #1;
        chk("R4 flush valid", 32'(dn_valid), 32'd1);
        chk("R4 flush addr", dn_addr, 32'h80);
        chk("R4 flush dir", 32'(dn_is_write), 32'd1);
        step(); step();
        set_up(1'b1, 1'b1, 32'h84);
        #1;
        chk("R4 direct write valid", 32'(dn_valid), 32'd1);
        chk("R4 direct write addr", dn_addr, 32'h84);
        step();
        set_up(1'b0, 1'b0, '0);
    endtask

    task automatic t_hazard_drain();
        logic [31:0] wexp [3];
        logic [31:0] rexp [3];
        wexp = '{32'h20, 32'h24, 32'h50};
        rexp = '{32'h20, 32'h40, 32'h60};
        do_reset();
        set_up(1'b1, 1'b0, 32'h10);
        #1;
        chk("R2 pass valid", 32'(dn_valid), 32'd1);
        chk("R2 pass addr", dn_addr, 32'h10);
        chk("R2 pass dir", 32'(dn_is_write), 32'd0);
        step();
        set_up(1'b1, 1'b1, 32'h20);
        #1;
        chk("R3 write held", 32'(dn_valid), 32'd0);
        chk("R3 write accepted", 32'(up_ready), 32'd1);
        step();
        set_up(1'b1, 1'b1, 32'h24);
        step();
        set_up(1'b1, 1'b0, 32'h30);
        #1;
        chk("R2 pass with held writes", dn_addr, 32'h30);
        chk("R2 pass valid 2", 32'(dn_valid), 32'd1);
        step();
        set_up(1'b1, 1'b0, 32'h20);
        #1;
        chk("R5 hazard read held", 32'(dn_valid), 32'd0);
        chk("R5 hazard read accepted", 32'(up_ready), 32'd1);
        step();
        set_up(1'b1, 1'b0, 32'h40);
        #1;
        chk("R5 hold read not sent", 32'(dn_valid), 32'd0);
        step();
        set_up(1'b1, 1'b1, 32'h50);
        #1;
        chk("R5 hold write not sent", 32'(dn_valid), 32'd0);
        step();
        set_up(1'b0, 1'b0, '0);
        done = 1'b1;
        step();
        #1;
        chk("R11 one outstanding left", 32'(dn_valid), 32'd0);
        step();
        done = 1'b0;
        set_up(1'b1, 1'b0, 32'h60);
        dn_ready = 1'b0;
        #1;
        chk("R9 up_ready low in flush", 32'(up_ready), 32'd0);
        chk("R6 first write addr", dn_addr, 32'h20);
        chk("R6 first write dir", 32'(dn_is_write), 32'd1);
        step();
        #1;
        chk("R9 stalled entry kept", dn_addr, 32'h20);
        chk("R9 stalled valid kept", 32'(dn_valid), 32'd1);
        dn_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R6 write order", dn_addr, wexp[i]);
            chk("R6 write valid", 32'(dn_valid), 32'd1);
            step();
        end
        #1;
        chk("R9 up_ready low at flush end", 32'(up_ready), 32'd0);
        step();
        #1;
        chk("R7 read held in write mode", 32'(dn_valid), 32'd0);
        chk("R7 read accepted", 32'(up_ready), 32'd1);
        step();
        set_up(1'b1, 1'b1, 32'h70);
        #1;
        chk("R7 write direct valid", 32'(dn_valid), 32'd1);
        chk("R7 write direct addr", dn_addr, 32'h70);
        step();
        set_up(1'b0, 1'b0, '0);
        done = 1'b1;
        step(); step(); step(); step();
        done = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R8 read order", dn_addr, rexp[i]);
            chk("R8 read dir", 32'(dn_is_write), 32'd0);
            chk("R8 read valid", 32'(dn_valid), 32'd1);
            step();
        end
        #1;
        chk("R8 queue empty", 32'(dn_valid), 32'd0);
        step();
        set_up(1'b1, 1'b0, 32'h20);
        #1;
        chk("R8 back in read mode", 32'(dn_valid), 32'd1);
        step();
        set_up(1'b0, 1'b0, '0);
    endtask

    task automatic t_count_to_zero();
        do_reset();
        set_up(1'b1, 1'b0, 32'h90);
        step();
        set_up(1'b1, 1'b0, 32'h94);
        step();
        set_up(1'b1, 1'b1, 32'hA0);
        step();
        set_up(1'b0, 1'b0, '0);
        done = 1'b1;
        step();
        done = 1'b0;
        #1;
        chk("R11 not yet zero", 32'(dn_valid), 32'd0);
        done = 1'b1;
        step();
        done = 1'b0;
        #1;
        chk("R6 queued write released", 32'(dn_valid), 32'd1);
        chk("R6 queued write addr", dn_addr, 32'hA0);
        step();
    endtask

    task automatic t_queue_full();
        do_reset();
        set_up(1'b1, 1'b0, 32'h1000);
        step();
        for (int i = 0; i < 8; i++) begin
            set_up(1'b1, 1'b1, 32'h100 + 32'(4 * i));
            step();
        end
        set_up(1'b1, 1'b1, 32'h200);
        #1;
        chk("R10 full refuses", 32'(up_ready), 32'd0);
        step();
        set_up(1'b0, 1'b0, '0);
        done = 1'b1;
        step();
        done = 1'b0;
        for (int i = 0; i < 8; i++) begin
            #1;
            chk("R10 stored entry", dn_addr, 32'h100 + 32'(4 * i));
            step();
        end
        #1;
        chk("R10 refused not stored", 32'(dn_valid), 32'd0);
    endtask

    initial begin
        t_reset_state();
        t_idle_write();
        t_hazard_drain();
        t_count_to_zero();
        t_queue_full();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule